// File: doc/BRIEF.md
# Chained Frame Descriptor Fetcher

This block serves one channel of a descriptor-driven display DMA. Each time the frame timing logic pulses a frame start while the channel is enabled, the block picks the address of the next descriptor. That address is either the pointer left behind by the previous descriptor or a one-shot override that software has placed in a branch register. The block then checks that all 16 bytes of the descriptor lie inside one of two permitted memory windows. If they do, it reads the four descriptor words one beat at a time over a valid/ready read port.

The four words are, in memory order, the pointer to the following descriptor, the frame source address, a frame identifier and a command word. When the fetch is over, the block inspects the source address. A usable source starts the pixel transfer, which is handled elsewhere, through a one-cycle go pulse. A source that is zero or lies outside both windows produces a bus-error pulse instead. Start and end markers, plus a branch marker, go to a separate status block as single-cycle pulses. The command word's length and palette flag are decoded for the downstream engine.

Top module: `desc_fetch_chan`

## Requirements
- R1: After synchronous reset, every descriptor register and the branch register read zero, `fetch_busy` is low and no event pulse is high.
- R2: A write to the next-descriptor register stores the data ANDed with 0xFFFFFFF0. A write to the branch register stores the data ANDed with 0xFFFFFFF3. In the branch register, bits 31:4 are the override address, bit 1 is the branch-interrupt enable and bit 0 is the branch request.
- R3: A frame start is ignored, with no reads, no events and no change to the branch register, when `chan_en` is low or while a fetch is already in progress.
- R4: On an accepted frame start, if branch bit 0 is set, the descriptor address is the branch register with bits 3:0 zeroed and bit 0 of the branch register is cleared. Otherwise the descriptor address is the stored next-descriptor value.
- R5: `ev_branch` pulses for one cycle exactly when a branch request is consumed while branch bit 1 is set.
- R6: A fetch issues four reads at the descriptor address plus 0, 4, 8 and 12, in that order. These load next-descriptor, source, frame ID and command. Each request holds its address steady until `mem_rd_ready` is seen.
- R7: The source register reads zero from the cycle after an accepted frame start. The reads are issued only if the descriptor address A satisfies base <= A and A+16 <= base+size for one of the two windows; otherwise no read occurs.
- R8: When the fetch ends, a source that is zero or outside both windows (base <= S < base+size fails for each) gives one `ev_bus_err` pulse and no `frame_go`.
- R9: A valid source gives one `frame_go` pulse. `ev_sof` pulses in the same cycle if command bit 22 is set.
- R10: `xfer_done` while a frame is active ends the frame, and `ev_eof` pulses one cycle later if command bit 21 is set. After a bus error no frame is active and `xfer_done` yields no `ev_eof`.
- R11: `xfer_len_o` equals command bits 20:2 followed by two zero bits, and `pal_load_o` equals command bit 26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; fetches happen only when high |
| frame_start | input | 1 | Frame start strobe |
| xfer_done | input | 1 | Pixel transfer for the current frame finished |
| nd_wr_en | input | 1 | Software write strobe, next-descriptor register |
| nd_wr_data | input | 32 | Write data, next-descriptor register |
| br_wr_en | input | 1 | Software write strobe, branch register |
| br_wr_data | input | 32 | Write data, branch register |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_addr | output | 32 | Read request byte address |
| mem_rd_ready | input | 1 | Read accepted; data valid in the same cycle |
| mem_rd_data | input | 32 | Read data |
| next_desc_o | output | 32 | Next-descriptor register |
| src_addr_o | output | 32 | Frame source address register |
| frame_id_o | output | 32 | Frame ID register |
| cmd_o | output | 32 | Command register |
| branch_o | output | 32 | Branch register |
| xfer_len_o | output | 21 | Transfer length in bytes from the command |
| pal_load_o | output | 1 | Palette-load flag from the command |
| fetch_busy | output | 1 | A fetch sequence is in progress |
| frame_go | output | 1 | Pulse: frame accepted, start transfer |
| ev_branch | output | 1 | Pulse: branch event |
| ev_bus_err | output | 1 | Pulse: bus error on this channel |
| ev_sof | output | 1 | Pulse: start-of-frame marker |
| ev_eof | output | 1 | Pulse: end-of-frame marker |

## Verification
The bench walks descriptor addresses across both edges of both windows. A window test that checks only the start address would fetch a descriptor at 16 bytes below a window's end plus one line, or one that straddles the end; an off-by-one limit would reject the last legal slot. Source addresses are probed at zero, at the last byte of each window and one byte past it. A design that skipped clearing the source before a rejected fetch would let a stale source through as a valid frame. Branch handling is checked for one-shot behaviour and for interrupt gating, and for staying untouched when the channel is disabled. A sticky request would keep re-fetching the override. All eight combinations of start/end/palette command bits are swept under ready stalls, which catches a request that moves while stalled or words loaded into the wrong register.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_WIN    = 2;
    localparam int DESC_BYTES = 16;
    localparam int LEN_W      = 21;

    localparam logic [WORD_W-1:0] NEXT_WMASK   = 32'hFFFF_FFF0;
    localparam logic [WORD_W-1:0] BRANCH_WMASK = 32'hFFFF_FFF3;

    localparam int BR_REQ_BIT  = 0;
    localparam int BR_INT_BIT  = 1;
    localparam int CMD_EOF_BIT = 21;
    localparam int CMD_SOF_BIT = 22;
    localparam int CMD_PAL_BIT = 26;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACHK,
        ST_RD0,
        ST_RD1,
        ST_RD2,
        ST_RD3,
        ST_DONE
    } fetch_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] next;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] fid;
        logic [WORD_W-1:0] cmd;
    } desc_t;

    typedef struct packed {
        logic brch;
        logic berr;
        logic go;
        logic sof;
        logic eof;
    } evt_t;

    function automatic logic [WORD_W-1:0] branch_target(input logic [WORD_W-1:0] b);
        return {b[WORD_W-1:4], 4'b0000};
    endfunction

    function automatic logic [LEN_W-1:0] cmd_length(input logic [WORD_W-1:0] c);
        return {c[LEN_W-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/dfc_branch_reg.sv
module dfc_branch_reg
    import dfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              take,
    output logic [WORD_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (wr_en) begin
            value <= wr_data & BRANCH_WMASK;
        end else if (take) begin
            value[BR_REQ_BIT] <= 1'b0;
        end
    end
endmodule

// File: rtl/dfc_win_check.sv
module dfc_win_check
    import dfc_pkg::*;
#(
    parameter int                             N_WIN = NUM_WIN,
    parameter logic [N_WIN-1:0][WORD_W-1:0]   BASES = '0,
    parameter logic [N_WIN-1:0][WORD_W-1:0]   SIZES = '0,
    parameter int                             SPAN  = 1
) (
    input  logic [WORD_W-1:0] addr,
    output logic              ok
);
    localparam int EXT_W = WORD_W + 1;

    logic [N_WIN-1:0] hit;
    logic [EXT_W-1:0] lo_ext;
    logic [EXT_W-1:0] hi_ext;

    assign lo_ext = {1'b0, addr};
    assign hi_ext = lo_ext + EXT_W'(SPAN);

    for (genvar i = 0; i < N_WIN; i++) begin : g_win
        logic [EXT_W-1:0] base_ext;
        logic [EXT_W-1:0] limit_ext;
        assign base_ext  = {1'b0, BASES[i]};
        assign limit_ext = base_ext + {1'b0, SIZES[i]};
        assign hit[i]    = (lo_ext >= base_ext) && (hi_ext <= limit_ext);
    end

    assign ok = |hit;
endmodule

// File: rtl/dfc_fetch_fsm.sv
module dfc_fetch_fsm
    import dfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_en,
    input  logic              frame_start,
    input  logic              xfer_done,
    input  logic              nd_wr_en,
    input  logic [WORD_W-1:0] nd_wr_data,
    input  logic [WORD_W-1:0] branch_q,
    input  logic              desc_ok,
    input  logic              src_ok,
    input  logic              mem_rd_ready,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              take_branch,
    output logic [WORD_W-1:0] desc_addr,
    output desc_t             desc,
    output logic              mem_rd_valid,
    output logic [WORD_W-1:0] mem_rd_addr,
    output evt_t              evt,
    output logic              busy
);
    fetch_state_t state;
    logic         active;
    logic         start;
    logic [1:0]   beat;

    assign start       = (state == ST_IDLE) && frame_start && chan_en;
    assign take_branch = start && branch_q[BR_REQ_BIT];
    assign busy        = (state != ST_IDLE);

    always_comb begin
        mem_rd_valid = 1'b1;
        beat         = 2'd0;
        case (state)
            ST_RD0:  beat = 2'd0;
            ST_RD1:  beat = 2'd1;
            ST_RD2:  beat = 2'd2;
            ST_RD3:  beat = 2'd3;
            default: mem_rd_valid = 1'b0;
        endcase
    end

    assign mem_rd_addr = desc_addr + {{(WORD_W-4){1'b0}}, beat, 2'b00};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            desc_addr <= '0;
            desc      <= '0;
            evt       <= '0;
            active    <= 1'b0;
        end else begin
            evt <= '0;
            if (nd_wr_en) begin
                desc.next <= nd_wr_data & NEXT_WMASK;
            end
            if (xfer_done && active) begin
                evt.eof <= desc.cmd[CMD_EOF_BIT];
                active  <= 1'b0;
            end
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        desc_addr <= take_branch ? branch_target(branch_q) : desc.next;
                        desc.src  <= '0;
                        active    <= 1'b0;
                        evt.brch  <= take_branch && branch_q[BR_INT_BIT];
                        state     <= ST_ACHK;
                    end
                end
                ST_ACHK: state <= desc_ok ? ST_RD0 : ST_DONE;
                ST_RD0: if (mem_rd_ready) begin
                    desc.next <= mem_rd_data;
                    state     <= ST_RD1;
                end
                ST_RD1: if (mem_rd_ready) begin
                    desc.src <= mem_rd_data;
                    state    <= ST_RD2;
                end
                ST_RD2: if (mem_rd_ready) begin
                    desc.fid <= mem_rd_data;
                    state    <= ST_RD3;
                end
                ST_RD3: if (mem_rd_ready) begin
                    desc.cmd <= mem_rd_data;
                    state    <= ST_DONE;
                end
                ST_DONE: begin
                    if (src_ok && (desc.src != '0)) begin
                        evt.go  <= 1'b1;
                        evt.sof <= desc.cmd[CMD_SOF_BIT];
                        active  <= 1'b1;
                    end else begin
                        evt.berr <= 1'b1;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/desc_fetch_chan.sv
module desc_fetch_chan
    import dfc_pkg::*;
#(
    parameter logic [31:0] WIN0_BASE = 32'hA000_0000,
    parameter logic [31:0] WIN0_SIZE = 32'h0400_0000,
    parameter logic [31:0] WIN1_BASE = 32'h5C00_0000,
    parameter logic [31:0] WIN1_SIZE = 32'h0004_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        chan_en,
    input  logic        frame_start,
    input  logic        xfer_done,
    input  logic        nd_wr_en,
    input  logic [31:0] nd_wr_data,
    input  logic        br_wr_en,
    input  logic [31:0] br_wr_data,
    output logic        mem_rd_valid,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_ready,
    input  logic [31:0] mem_rd_data,
    output logic [31:0] next_desc_o,
    output logic [31:0] src_addr_o,
    output logic [31:0] frame_id_o,
    output logic [31:0] cmd_o,
    output logic [31:0] branch_o,
    output logic [20:0] xfer_len_o,
    output logic        pal_load_o,
    output logic        fetch_busy,
    output logic        frame_go,
    output logic        ev_branch,
    output logic        ev_bus_err,
    output logic        ev_sof,
    output logic        ev_eof
);
    localparam logic [NUM_WIN-1:0][WORD_W-1:0] BASES = {WIN1_BASE, WIN0_BASE};
    localparam logic [NUM_WIN-1:0][WORD_W-1:0] SIZES = {WIN1_SIZE, WIN0_SIZE};

    logic              take_branch;
    logic [WORD_W-1:0] branch_q;
    logic [WORD_W-1:0] desc_addr;
    logic              desc_ok;
    logic              src_ok;
    desc_t             desc;
    evt_t              evt;

    dfc_branch_reg u_branch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (br_wr_en),
        .wr_data (br_wr_data),
        .take    (take_branch),
        .value   (branch_q)
    );

    dfc_win_check #(.N_WIN(NUM_WIN), .BASES(BASES), .SIZES(SIZES), .SPAN(DESC_BYTES)) u_desc_win (
        .addr (desc_addr),
        .ok   (desc_ok)
    );

    dfc_win_check #(.N_WIN(NUM_WIN), .BASES(BASES), .SIZES(SIZES), .SPAN(1)) u_src_win (
        .addr (desc.src),
        .ok   (src_ok)
    );

    dfc_fetch_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .chan_en      (chan_en),
        .frame_start  (frame_start),
        .xfer_done    (xfer_done),
        .nd_wr_en     (nd_wr_en),
        .nd_wr_data   (nd_wr_data),
        .branch_q     (branch_q),
        .desc_ok      (desc_ok),
        .src_ok       (src_ok),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_data  (mem_rd_data),
        .take_branch  (take_branch),
        .desc_addr    (desc_addr),
        .desc         (desc),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_addr  (mem_rd_addr),
        .evt          (evt),
        .busy         (fetch_busy)
    );

    assign next_desc_o = desc.next;
    assign src_addr_o  = desc.src;
    assign frame_id_o  = desc.fid;
    assign cmd_o       = desc.cmd;
    assign branch_o    = branch_q;
    assign xfer_len_o  = cmd_length(desc.cmd);
    assign pal_load_o  = desc.cmd[CMD_PAL_BIT];
    assign frame_go    = evt.go;
    assign ev_branch   = evt.brch;
    assign ev_bus_err  = evt.berr;
    assign ev_sof      = evt.sof;
    assign ev_eof      = evt.eof;
endmodule

// File: rtl/dfc_checker.sv
module dfc_checker #(
    parameter logic [31:0] W0_BASE = 32'h0,
    parameter logic [31:0] W0_SIZE = 32'h0,
    parameter logic [31:0] W1_BASE = 32'h0,
    parameter logic [31:0] W1_SIZE = 32'h0
) (
    input logic        clk,
    input logic        rst,
    input logic        chan_en,
    input logic        xfer_done,
    input logic        br_wr_en,
    input logic        mem_rd_valid,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_ready,
    input logic [31:0] src_addr_o,
    input logic [31:0] branch_o,
    input logic        fetch_busy,
    input logic        frame_go,
    input logic        ev_branch,
    input logic        ev_bus_err,
    input logic        ev_sof,
    input logic        ev_eof
);
    logic [63:0] a64;
    logic        rd_in_win;
    assign a64 = {32'd0, mem_rd_addr};
    assign rd_in_win = ((a64 >= {32'd0, W0_BASE}) && (a64 + 64'd4 <= {32'd0, W0_BASE} + {32'd0, W0_SIZE})) ||
                       ((a64 >= {32'd0, W1_BASE}) && (a64 + 64'd4 <= {32'd0, W1_BASE} + {32'd0, W1_SIZE}));

    p_idle_when_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        (!fetch_busy && !chan_en) |=> !fetch_busy);

    p_branch_one_shot_r4: assert property (@(posedge clk) disable iff (rst)
        (ev_branch && !$past(br_wr_en)) |-> !branch_o[0]);

    p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    p_rd_in_window_r7: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> rd_in_win);

    p_src_cleared_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_busy) |-> (src_addr_o == 32'd0));

    p_go_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(frame_go && ev_bus_err));

    p_go_nonzero_src_r8: assert property (@(posedge clk) disable iff (rst)
        frame_go |-> (src_addr_o != 32'd0));

    p_sof_with_go_r9: assert property (@(posedge clk) disable iff (rst)
        ev_sof |-> frame_go);

    p_eof_cause_r10: assert property (@(posedge clk) disable iff (rst)
        ev_eof |-> $past(xfer_done));
endmodule

bind desc_fetch_chan dfc_checker #(
    .W0_BASE(WIN0_BASE), .W0_SIZE(WIN0_SIZE), .W1_BASE(WIN1_BASE), .W1_SIZE(WIN1_SIZE)
) u_dfc_checker (
    .clk          (clk),
    .rst          (rst),
    .chan_en      (chan_en),
    .xfer_done    (xfer_done),
    .br_wr_en     (br_wr_en),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ready (mem_rd_ready),
    .src_addr_o   (src_addr_o),
    .branch_o     (branch_o),
    .fetch_busy   (fetch_busy),
    .frame_go     (frame_go),
    .ev_branch    (ev_branch),
    .ev_bus_err   (ev_bus_err),
    .ev_sof       (ev_sof),
    .ev_eof       (ev_eof)
);

// File: tb/desc_fetch_chan_tb.sv
module desc_fetch_chan_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] W0B = 32'hA000_0000;
    localparam logic [31:0] W0S = 32'h0400_0000;
    localparam logic [31:0] W1B = 32'h5C00_0000;
    localparam logic [31:0] W1S = 32'h0004_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_en = 1'b0;
    logic        frame_start = 1'b0;
    logic        xfer_done = 1'b0;
    logic        nd_wr_en = 1'b0;
    logic [31:0] nd_wr_data = '0;
    logic        br_wr_en = 1'b0;
    logic [31:0] br_wr_data = '0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic [31:0] next_desc_o, src_addr_o, frame_id_o, cmd_o, branch_o;
    logic [20:0] xfer_len_o;
    logic        pal_load_o, fetch_busy, frame_go, ev_branch, ev_bus_err, ev_sof, ev_eof;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_fetch_chan #(.WIN0_BASE(W0B), .WIN0_SIZE(W0S), .WIN1_BASE(W1B), .WIN1_SIZE(W1S)) dut_i (
        .clk(clk), .rst(rst), .chan_en(chan_en), .frame_start(frame_start), .xfer_done(xfer_done),
        .nd_wr_en(nd_wr_en), .nd_wr_data(nd_wr_data), .br_wr_en(br_wr_en), .br_wr_data(br_wr_data),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
        .mem_rd_data(mem_rd_data), .next_desc_o(next_desc_o), .src_addr_o(src_addr_o),
        .frame_id_o(frame_id_o), .cmd_o(cmd_o), .branch_o(branch_o), .xfer_len_o(xfer_len_o),
        .pal_load_o(pal_load_o), .fetch_busy(fetch_busy), .frame_go(frame_go), .ev_branch(ev_branch),
        .ev_bus_err(ev_bus_err), .ev_sof(ev_sof), .ev_eof(ev_eof)
    );

    int checks = 0;
    int errors = 0;
    int stall_mode = 0;
    int cyc = 0;
    logic [31:0] mem [0:127];
    int n_beats, n_go, n_berr, n_brch, n_sof, n_eof;
    logic [31:0] beat_addr [0:7];

    // memory responder: updates just after each rising edge
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        mem_rd_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) == 2);
        mem_rd_data  = mem[mem_rd_addr[8:2]];
    end

    // event monitor away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd_valid && mem_rd_ready) begin
                if (n_beats < 8) beat_addr[n_beats] = mem_rd_addr;
                n_beats = n_beats + 1;
            end
            if (frame_go)   n_go   = n_go + 1;
            if (ev_bus_err) n_berr = n_berr + 1;
            if (ev_branch)  n_brch = n_brch + 1;
            if (ev_sof)     n_sof  = n_sof + 1;
            if (ev_eof)     n_eof  = n_eof + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_beats = 0; n_go = 0; n_berr = 0; n_brch = 0; n_sof = 0; n_eof = 0;
    endtask

    function automatic bit src_valid(input logic [31:0] a);
        longint x = longint'(a);
        return (a != 0) && (((x >= longint'(W0B)) && (x < longint'(W0B) + longint'(W0S))) ||
                            ((x >= longint'(W1B)) && (x < longint'(W1B) + longint'(W1S))));
    endfunction

    function automatic bit desc_valid(input logic [31:0] a);
        longint x = longint'(a);
        return ((x >= longint'(W0B)) && (x + 16 <= longint'(W0B) + longint'(W0S))) ||
               ((x >= longint'(W1B)) && (x + 16 <= longint'(W1B) + longint'(W1S)));
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] sr,
                            input logic [31:0] id, input logic [31:0] cm);
        mem[a[8:2]]      = nx;
        mem[a[8:2] + 1]  = sr;
        mem[a[8:2] + 2]  = id;
        mem[a[8:2] + 3]  = cm;
    endtask

    task automatic write_next(input logic [31:0] d);
        @(negedge clk); nd_wr_en = 1'b1; nd_wr_data = d;
        @(negedge clk); nd_wr_en = 1'b0;
    endtask

    task automatic write_branch(input logic [31:0] d);
        @(negedge clk); br_wr_en = 1'b1; br_wr_data = d;
        @(negedge clk); br_wr_en = 1'b0;
    endtask

    task automatic run_frame(input int start_len);
        clear_counts();
        @(negedge clk); frame_start = 1'b1;
        repeat (start_len) @(negedge clk);
        frame_start = 1'b0;
        for (int i = 0; i < 200 && fetch_busy; i++) @(negedge clk);
        if (fetch_busy) check("R6 fetch completes", 32'd1, 32'd0);
        @(negedge clk);
    endtask

    task automatic end_xfer();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_beats(input logic [31:0] base);
        check("R6 beat count", 32'(n_beats), 32'd4);
        for (int k = 0; k < 4; k++) check("R6 beat address", beat_addr[k], base + 32'(4 * k));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        clear_counts();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 next", next_desc_o, 32'd0);
        check("R1 src", src_addr_o, 32'd0);
        check("R1 fid", frame_id_o, 32'd0);
        check("R1 cmd", cmd_o, 32'd0);
        check("R1 branch", branch_o, 32'd0);
        check("R1 busy", {31'd0, fetch_busy}, 32'd0);
        check("R1 events", {27'd0, frame_go, ev_branch, ev_bus_err, ev_sof, ev_eof}, 32'd0);

        // R2 write masks
        write_next(32'hA000_001F);
        check("R2 next mask", next_desc_o, 32'hA000_0010);
        write_branch(32'hFFFF_FFFF);
        check("R2 branch mask", branch_o, 32'hFFFF_FFF3);
        write_branch(32'h0);
        chan_en = 1'b1;

        // R6 R9 R10 R11 sweep over command flag combinations and stall patterns
        for (int c = 0; c < 8; c++) begin
            logic [31:0] len, cm, sr;
            len = 32'(c) * 32'h104 + 32'h10;
            cm  = (len & 32'h001F_FFFC) | (32'(c & 1) << 22) | (32'((c >> 1) & 1) << 21) |
                  (32'((c >> 2) & 1) << 26) | 32'h4000_0000;
            sr  = 32'hA000_1000 + 32'(c * 16);
            stall_mode = c & 1;
            put_desc(32'hA000_0010, 32'hA000_0010, sr, 32'h50 + 32'(c), cm);
            run_frame(1);
            check_beats(32'hA000_0010);
            check("R6 next loaded", next_desc_o, 32'hA000_0010);
            check("R6 src loaded", src_addr_o, sr);
            check("R6 fid loaded", frame_id_o, 32'h50 + 32'(c));
            check("R6 cmd loaded", cmd_o, cm);
            check("R9 frame_go", 32'(n_go), 32'd1);
            check("R9 sof", 32'(n_sof), 32'(c & 1));
            check("R8 no bus err", 32'(n_berr), 32'd0);
            check("R11 length", {11'd0, xfer_len_o}, len);
            check("R11 palette", {31'd0, pal_load_o}, 32'((c >> 2) & 1));
            clear_counts();
            end_xfer();
            check("R10 eof", 32'(n_eof), 32'((c >> 1) & 1));
        end
        stall_mode = 0;

        // R4 chain + R3 double start while busy
        put_desc(32'hA000_0010, 32'hA000_0040, 32'hA000_2000, 32'h1, 32'h0);
        put_desc(32'hA000_0040, 32'hA000_0010, 32'hA000_3000, 32'h2, 32'h0);
        run_frame(2);
        check("R3 single fetch while busy", 32'(n_beats), 32'd4);
        check("R3 single go", 32'(n_go), 32'd1);
        run_frame(1);
        check_beats(32'hA000_0040);
        check("R4 chained src", src_addr_o, 32'hA000_3000);

        // R4 R5 branch with interrupt
        put_desc(32'hA000_0080, 32'hA000_0010, 32'hA000_4000, 32'h3, 32'h0);
        write_branch(32'hA000_0083);
        run_frame(1);
        check_beats(32'hA000_0080);
        check("R5 branch event", 32'(n_brch), 32'd1);
        check("R4 request cleared", branch_o, 32'hA000_0082);
        run_frame(1);
        check_beats(32'hA000_0010);
        check("R5 no event without request", 32'(n_brch), 32'd0);

        // R5 branch without interrupt
        put_desc(32'hA000_00C0, 32'hA000_0010, 32'hA000_5000, 32'h4, 32'h0);
        write_branch(32'hA000_00C1);
        run_frame(1);
        check_beats(32'hA000_00C0);
        check("R5 no event when bit1 clear", 32'(n_brch), 32'd0);
        check("R4 request cleared", branch_o, 32'hA000_00C0);

        // R3 disabled channel
        write_branch(32'hA000_0081);
        chan_en = 1'b0;
        run_frame(1);
        check("R3 no reads when disabled", 32'(n_beats), 32'd0);
        check("R3 branch untouched", branch_o, 32'hA000_0081);
        check("R3 no events", 32'(n_go + n_berr + n_brch), 32'd0);
        chan_en = 1'b1;
        run_frame(1);
        check_beats(32'hA000_0080);
        check("R4 branch after enable", branch_o, 32'hA000_0080);

        // R7 descriptor window edges
        begin
            logic [31:0] edges [0:7];
            edges[0] = 32'hA000_0000; edges[1] = 32'h9FFF_FFF0;
            edges[2] = 32'hA3FF_FFF0; edges[3] = 32'hA400_0000;
            edges[4] = 32'h5C00_0000; edges[5] = 32'h5C03_FFF0;
            edges[6] = 32'h5C04_0000; edges[7] = 32'h0000_0000;
            for (int e = 0; e < 8; e++) begin
                bit ok;
                ok = desc_valid(edges[e]);
                put_desc(edges[e], 32'hA000_0010, 32'hA000_6000, 32'h60, 32'h0);
                write_branch(edges[e] | 32'h1);
                run_frame(1);
                check("R7 reads when in window", 32'(n_beats), ok ? 32'd4 : 32'd0);
                check("R7 go", 32'(n_go), 32'(ok));
                check("R8 bus err on rejected desc", 32'(n_berr), 32'(!ok));
                if (!ok) check("R7 source cleared", src_addr_o, 32'd0);
                else     check_beats(edges[e]);
            end
        end

        // R8 R10 source checks
        begin
            logic [31:0] srcs [0:6];
            srcs[0] = 32'h0000_0000; srcs[1] = 32'hA400_0000; srcs[2] = 32'hA3FF_FFFF;
            srcs[3] = 32'h5C03_FFFF; srcs[4] = 32'h5C04_0000; srcs[5] = 32'h1234_5678;
            srcs[6] = 32'h9FFF_FFFF;
            for (int s = 0; s < 7; s++) begin
                bit ok;
                ok = src_valid(srcs[s]);
                put_desc(32'hA000_0010, 32'hA000_0010, srcs[s], 32'h70, 32'h0060_0000);
                write_next(32'hA000_0010);
                run_frame(1);
                check("R8 bus error", 32'(n_berr), 32'(!ok));
                check("R8 go", 32'(n_go), 32'(ok));
                check("R9 sof only with go", 32'(n_sof), 32'(ok));
                clear_counts();
                end_xfer();
                check("R10 eof only after go", 32'(n_eof), 32'(ok));
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule